// File: doc/BRIEF.md
# Flash Protected-Range Checker

This block sits between a flash cycle requester and the serial flash sequencer. It decides, for every requested cycle, whether that cycle may reach the flash device. Five independent range registers each describe a window of the 25-bit flash linear address space at 4 KiB granularity. Each window can deny reads, deny modifying cycles (writes and erases), or both. A cycle is presented with its address, its kind and a valid strobe. One clock later the block answers with either allow or block. A blocked cycle also raises a sticky error flag, which software clears by writing a one to it.

The range registers can be written freely after reset, so firmware can set them up. Once the lockdown input has been pulsed, the registers are frozen until the next reset and the ranges start to be enforced. Before lockdown, every cycle is allowed. Readback of a range register goes through a combinational read port, and the reserved bits read back as zero.

Top module: `flash_range_guard`

## Requirements
- R1: After a synchronous reset, all range registers read zero, `locked` is 0, `err_flag` is 0 and `dec_valid`, `dec_allow` and `dec_block` are all 0.
- R2: While unlocked, a write with `cfg_wr_idx` 0..4 stores `cfg_wr_data` into that range register. Readback through `cfg_rd_idx` returns the stored word with bits 30:29 and 14:13 forced to zero. Register layout: bit 31 is the write-protect enable, bits 28:16 are the upper limit (address bits 24:12), bit 15 is the read-protect enable, and bits 12:0 are the lower limit (address bits 24:12). A write with an index of 5 or more changes nothing, and reading such an index returns zero.
- R3: A one on `lock_set` sets `locked` from the next clock on. `locked` then stays set until reset, and every later register write is ignored.
- R4: While `locked` is 0 (including the cycle in which `lock_set` is first asserted), every presented cycle is allowed, whatever the ranges hold.
- R5: An address hits a range when it is at least {lower, 12'h000} and at most {upper, 12'hFFF}. Both bounds are inclusive.
- R6: `cyc_kind` encodes 00 as read, 01 as write, 10 as erase and 11 as a modifying cycle. A read is blocked only by a hit range with its read-protect enable set. Any other kind is blocked only by a hit range with its write-protect enable set.
- R7: When locked, a cycle is blocked if any one of the five ranges blocks it. A range whose lower limit exceeds its upper limit hits no address.
- R8: The verdict is registered. The clock after `cyc_valid` is high, `dec_valid` is 1 and exactly one of `dec_allow` and `dec_block` is 1. The clock after `cyc_valid` is low, all three are 0.
- R9: `err_flag` rises on the same clock as `dec_block`. It stays set until a cycle with `err_clr` high that carries no blocked cycle, and on that clock it clears. A new block wins over a simultaneous clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Range register write strobe |
| cfg_wr_idx | input | 3 | Range register index for write |
| cfg_wr_data | input | 32 | Range register write word |
| cfg_rd_idx | input | 3 | Range register index for readback |
| cfg_rd_data | output | 32 | Readback word, reserved bits zero |
| lock_set | input | 1 | Pulse to engage lockdown |
| locked | output | 1 | Lockdown engaged |
| cyc_valid | input | 1 | Flash cycle request strobe |
| cyc_addr | input | 25 | Flash linear address of the cycle |
| cyc_kind | input | 2 | 00 read, 01 write, 10 erase, 11 modifying |
| dec_valid | output | 1 | Verdict present (one clock after request) |
| dec_allow | output | 1 | Cycle may proceed |
| dec_block | output | 1 | Cycle is refused |
| err_clr | input | 1 | Write-one-to-clear for the error flag |
| err_flag | output | 1 | Sticky blocked-cycle flag |

## Verification
The assertions check the following on every clock:
- the registered verdict follows the strobe;
- allow and block are exclusive;
- the block answers freely before lockdown;
- lockdown never drops, and the registers stay frozen under it;
- the error flag rises with each block and holds until cleared;
- reserved readback bits stay zero.

Which addresses actually hit a range cannot be seen by any of these properties. That covers the inclusive 4 KiB-aligned bounds, the choice of enable by cycle kind, the OR across five ranges and the inverted-window case. Only the bench scenarios show these, comparing against a behavioural model at both edges of each window and over random traffic.

// File: rtl/frg_pkg.sv
`timescale 1ns/1ps
package frg_pkg;

    localparam int ADDR_W    = 25;
    localparam int GRAN_W    = 12;
    localparam int LIM_W     = ADDR_W - GRAN_W;
    localparam int REG_W     = 32;
    localparam int WP_BIT    = 31;
    localparam int RP_BIT    = 15;
    localparam int UPPER_LSB = 16;
    localparam int LOWER_LSB = 0;

    localparam logic [REG_W-1:0] KEEP_MASK =
        (REG_W'(1) << WP_BIT) | (REG_W'(1) << RP_BIT) |
        (((REG_W'(1) << LIM_W) - 1) << UPPER_LSB) |
        (((REG_W'(1) << LIM_W) - 1) << LOWER_LSB);

    typedef logic [ADDR_W-1:0] faddr_t;
    typedef logic [LIM_W-1:0]  lim_t;

    typedef enum logic [1:0] {
        KIND_READ  = 2'b00,
        KIND_WRITE = 2'b01,
        KIND_ERASE = 2'b10,
        KIND_MOD   = 2'b11
    } kind_e;

    typedef struct packed {
        logic wp;
        logic rp;
        lim_t upper;
        lim_t lower;
    } range_t;

    typedef struct packed {
        logic valid;
        logic allow;
        logic block;
    } verdict_t;

    function automatic range_t unpack_range(input logic [REG_W-1:0] w);
        range_t r;
        r.wp    = w[WP_BIT];
        r.rp    = w[RP_BIT];
        r.upper = w[UPPER_LSB +: LIM_W];
        r.lower = w[LOWER_LSB +: LIM_W];
        return r;
    endfunction

    function automatic logic [REG_W-1:0] pack_range(input range_t r);
        logic [REG_W-1:0] w;
        w = '0;
        w[WP_BIT]             = r.wp;
        w[RP_BIT]             = r.rp;
        w[UPPER_LSB +: LIM_W] = r.upper;
        w[LOWER_LSB +: LIM_W] = r.lower;
        return w;
    endfunction

    function automatic logic is_read(input kind_e k);
        return k == KIND_READ;
    endfunction

endpackage

// File: rtl/frg_range_bank.sv
`timescale 1ns/1ps
module frg_range_bank
    import frg_pkg::*;
#(
    parameter int NUM_RANGES = 5,
    parameter int IDX_W      = $clog2(NUM_RANGES)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [REG_W-1:0]           wr_data,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [REG_W-1:0]           rd_data,
    input  logic                       lock_req,
    output logic                       locked,
    output range_t [NUM_RANGES-1:0]    ranges
);

    range_t [NUM_RANGES-1:0] ranges_q;
    logic                    locked_q;
    logic                    rsvd_unused;

    assign rsvd_unused = |(wr_data & ~KEEP_MASK);

    always_ff @(posedge clk) begin
        if (rst)           locked_q <= 1'b0;
        else if (lock_req) locked_q <= 1'b1;
    end

    for (genvar i = 0; i < NUM_RANGES; i++) begin : g_range
        always_ff @(posedge clk) begin
            if (rst)
                ranges_q[i] <= '0;
            else if (wr_en && !locked_q && wr_idx == IDX_W'(i))
                ranges_q[i] <= unpack_range(wr_data);
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_RANGES; i++)
            if (rd_idx == IDX_W'(i)) rd_data = pack_range(ranges_q[i]);
    end

    assign locked = locked_q;
    assign ranges = ranges_q;

    // R3
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        locked_q |=> locked_q);

    // R3
    frozen_chk: assert property (@(posedge clk) disable iff (rst)
        locked_q |=> $stable(ranges_q));

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~KEEP_MASK) == '0);

endmodule

// File: rtl/frg_range_cmp.sv
`timescale 1ns/1ps
module frg_range_cmp
    import frg_pkg::*;
(
    input  range_t rng,
    input  faddr_t addr,
    input  kind_e  kind,
    output logic   prot
);

    faddr_t lo_addr;
    faddr_t hi_addr;
    logic   hit;
    logic   en;

    assign lo_addr = {rng.lower, {GRAN_W{1'b0}}};
    assign hi_addr = {rng.upper, {GRAN_W{1'b1}}};
    assign hit     = (addr >= lo_addr) && (addr <= hi_addr);
    assign en      = is_read(kind) ? rng.rp : rng.wp;
    assign prot    = hit && en;

endmodule

// File: rtl/frg_verdict.sv
`timescale 1ns/1ps
module frg_verdict
    import frg_pkg::*;
#(
    parameter int NUM_RANGES = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cyc_valid,
    input  logic                  locked,
    input  logic [NUM_RANGES-1:0] prot_vec,
    input  logic                  err_clr,
    output verdict_t              verdict,
    output logic                  err_flag
);

    verdict_t v_q;
    logic     err_q;
    logic     refuse;

    assign refuse = cyc_valid && locked && (|prot_vec);

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q   <= '0;
            err_q <= 1'b0;
        end else begin
            v_q.valid <= cyc_valid;
            v_q.block <= refuse;
            v_q.allow <= cyc_valid && !refuse;
            if (refuse)       err_q <= 1'b1;
            else if (err_clr) err_q <= 1'b0;
        end
    end

    assign verdict  = v_q;
    assign err_flag = err_q;

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_valid |=> v_q.valid);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cyc_valid |=> !(v_q.valid || v_q.allow || v_q.block));

    // R8
    verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
        v_q.valid |-> ($countones({v_q.allow, v_q.block}) == 1));

    // R4
    open_until_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && !locked) |=> v_q.allow);

    // R9
    err_on_block_chk: assert property (@(posedge clk) disable iff (rst)
        v_q.block |-> err_q);

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q && !err_clr) |=> err_q);

    // R9
    err_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q && err_clr && !cyc_valid) |=> !err_q);

endmodule

// File: rtl/flash_range_guard.sv
`timescale 1ns/1ps
module flash_range_guard
    import frg_pkg::*;
#(
    parameter  int NUM_RANGES = 5,
    localparam int IDX_W      = $clog2(NUM_RANGES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr_en,
    input  logic [IDX_W-1:0]   cfg_wr_idx,
    input  logic [REG_W-1:0]   cfg_wr_data,
    input  logic [IDX_W-1:0]   cfg_rd_idx,
    output logic [REG_W-1:0]   cfg_rd_data,
    input  logic               lock_set,
    output logic               locked,
    input  logic               cyc_valid,
    input  logic [ADDR_W-1:0]  cyc_addr,
    input  logic [1:0]         cyc_kind,
    output logic               dec_valid,
    output logic               dec_allow,
    output logic               dec_block,
    input  logic               err_clr,
    output logic               err_flag
);

    range_t [NUM_RANGES-1:0] ranges;
    logic   [NUM_RANGES-1:0] prot_vec;
    verdict_t                verdict;
    kind_e                   kind;

    assign kind = kind_e'(cyc_kind);

    frg_range_bank #(.NUM_RANGES(NUM_RANGES), .IDX_W(IDX_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr_en),
        .wr_idx   (cfg_wr_idx),
        .wr_data  (cfg_wr_data),
        .rd_idx   (cfg_rd_idx),
        .rd_data  (cfg_rd_data),
        .lock_req (lock_set),
        .locked   (locked),
        .ranges   (ranges)
    );

    for (genvar i = 0; i < NUM_RANGES; i++) begin : g_cmp
        frg_range_cmp u_cmp (
            .rng  (ranges[i]),
            .addr (cyc_addr),
            .kind (kind),
            .prot (prot_vec[i])
        );
    end

    frg_verdict #(.NUM_RANGES(NUM_RANGES)) u_verdict (
        .clk       (clk),
        .rst       (rst),
        .cyc_valid (cyc_valid),
        .locked    (locked),
        .prot_vec  (prot_vec),
        .err_clr   (err_clr),
        .verdict   (verdict),
        .err_flag  (err_flag)
    );

    assign dec_valid = verdict.valid;
    assign dec_allow = verdict.allow;
    assign dec_block = verdict.block;

endmodule

// File: tb/test_flash_range_guard.sv
`timescale 1ns/1ps
module test_flash_range_guard;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_wr_idx = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [2:0]  cfg_rd_idx = '0;
    logic [31:0] cfg_rd_data;
    logic        lock_set = 1'b0;
    logic        locked;
    logic        cyc_valid = 1'b0;
    logic [24:0] cyc_addr = '0;
    logic [1:0]  cyc_kind = '0;
    logic        dec_valid, dec_allow, dec_block;
    logic        err_clr = 1'b0;
    logic        err_flag;

    int    tests = 0;
    int    fails = 0;
    bit    done  = 1'b0;
    string cur_tag = "R1";

    // behavioural reference state
    logic [31:0] mreg [0:4];
    bit          mlock, e_valid, e_allow, e_block, e_err, blk;
    logic [24:0] lo, hi;
    logic [31:0] rnd;

    always #10 clk = ~clk;   // 50 MHz

    flash_range_guard i_flash_range_guard (
        .clk(clk), .rst(rst),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_idx(cfg_rd_idx), .cfg_rd_data(cfg_rd_data),
        .lock_set(lock_set), .locked(locked),
        .cyc_valid(cyc_valid), .cyc_addr(cyc_addr), .cyc_kind(cyc_kind),
        .dec_valid(dec_valid), .dec_allow(dec_allow), .dec_block(dec_block),
        .err_clr(err_clr), .err_flag(err_flag)
    );

    task automatic chk1(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // reference model, updated on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 5; i++) mreg[i] = '0;
            mlock = 0; e_valid = 0; e_allow = 0; e_block = 0; e_err = 0;
        end else begin
            blk = 0;
            for (int i = 0; i < 5; i++) begin
                lo = {mreg[i][12:0], 12'h000};
                hi = {mreg[i][28:16], 12'hfff};
                if (cyc_addr >= lo && cyc_addr <= hi &&
                    ((cyc_kind == 2'b00) ? mreg[i][15] : mreg[i][31]))
                    blk = 1;
            end
            blk     = blk && mlock;
            e_valid = cyc_valid;
            e_block = cyc_valid && blk;
            e_allow = cyc_valid && !blk;
            if (e_block)      e_err = 1;
            else if (err_clr) e_err = 0;
            if (cfg_wr_en && !mlock && cfg_wr_idx < 5)
                mreg[cfg_wr_idx] = cfg_wr_data & 32'h9FFF9FFF;
            if (lock_set) mlock = 1;
        end
    end

    // compare against the model on every clock, a quarter period after the edge
    always @(posedge clk) begin
        #5;
        if (!done && !rst) begin
            chk1({cur_tag, " R8 dec_valid"}, dec_valid, e_valid);
            chk1({cur_tag, " R8 dec_allow"}, dec_allow, e_allow);
            chk1({cur_tag, " R8 dec_block"}, dec_block, e_block);
            chk1({cur_tag, " R9 err_flag"},  err_flag,  e_err);
            chk1({cur_tag, " R3 locked"},    locked,    mlock);
            chk32({cur_tag, " R2 rd_data"}, cfg_rd_data,
                  (cfg_rd_idx < 5) ? mreg[cfg_rd_idx] : 32'h0);
        end
    end

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1; cfg_wr_idx = idx; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] idx, input logic [31:0] exp);
        @(negedge clk);
        cfg_rd_idx = idx;
        @(posedge clk); #5;
        chk32(req, cfg_rd_data, exp);
    endtask

    task automatic cyc(input string req, input logic [24:0] a, input logic [1:0] k,
                       input logic exp_blk, input logic clr);
        @(negedge clk);
        cyc_valid = 1; cyc_addr = a; cyc_kind = k; err_clr = clr;
        @(posedge clk); #5;
        chk1(req, dec_block, exp_blk);
        chk1(req, dec_allow, !exp_blk);
        @(negedge clk);
        cyc_valid = 0; err_clr = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        cfg_wr_en = 0; lock_set = 0; cyc_valid = 0; err_clr = 0;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    task automatic random_traffic(input int n, input bit with_cfg);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rnd = $urandom;
            cyc_valid = rnd[0];
            cyc_kind  = rnd[2:1];
            err_clr   = (rnd[7:3] == 5'd0);
            rnd = $urandom;
            case (rnd[31:30])
                2'd0:    cyc_addr = {8'h01, rnd[16:0]};
                2'd1:    cyc_addr = {4'hF, rnd[20:0]} | 25'h1000000;
                2'd2:    cyc_addr = {5'h02, rnd[19:0]};
                default: cyc_addr = rnd[24:0];
            endcase
            cfg_rd_idx = rnd[29:27];
            if (with_cfg) begin
                rnd = $urandom;
                cfg_wr_en   = (rnd[2:0] == 3'd0);
                cfg_wr_idx  = rnd[5:3];
                cfg_wr_data = $urandom;
                lock_set    = (k == n / 3);
            end
        end
        @(negedge clk);
        cyc_valid = 0; err_clr = 0; cfg_wr_en = 0; lock_set = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 0;
        @(posedge clk); #5;
        // R1 reset state
        chk1("R1 locked", locked, 1'b0);
        chk1("R1 err_flag", err_flag, 1'b0);
        chk1("R1 dec_valid", dec_valid, 1'b0);
        chk1("R1 dec_block", dec_block, 1'b0);
        chk32("R1 rd r0", cfg_rd_data, 32'h0);

        // R2 programming, reserved bits dropped, out-of-range index ignored
        cur_tag = "R2";
        wr(3'd0, 32'hE01F6010);
        rd_chk("R2 r0 readback", 3'd0, 32'h801F0010);
        wr(3'd1, 32'h01008100);
        wr(3'd2, 32'h9FFF9F00);
        wr(3'd3, 32'h81FF8200);
        wr(3'd4, 32'h030F0300);
        rd_chk("R2 r2 readback", 3'd2, 32'h9FFF9F00);
        wr(3'd5, 32'hFFFFFFFF);
        rd_chk("R2 idx5 reads zero", 3'd5, 32'h0);
        rd_chk("R2 idx7 reads zero", 3'd7, 32'h0);
        rd_chk("R2 r4 untouched by idx5", 3'd4, 32'h030F0300);

        // R4 no enforcement before lockdown
        cur_tag = "R4";
        cyc("R4 write in r0 unlocked", 25'h0010000, 2'b01, 1'b0, 1'b0);
        cyc("R4 read in r2 unlocked", 25'h1FFFFFF, 2'b00, 1'b0, 1'b0);
        @(negedge clk);
        lock_set = 1; cyc_valid = 1; cyc_addr = 25'h0015000; cyc_kind = 2'b01;
        @(posedge clk); #5;
        chk1("R4 same-cycle lock still allows", dec_allow, 1'b1);
        @(negedge clk);
        lock_set = 0; cyc_valid = 0;

        // R3 lockdown sticky, registers frozen
        cur_tag = "R3";
        @(posedge clk); #5;
        chk1("R3 locked set", locked, 1'b1);
        wr(3'd0, 32'h00000000);
        rd_chk("R3 r0 frozen", 3'd0, 32'h801F0010);
        wr(3'd4, 32'hFFFFFFFF);
        rd_chk("R3 r4 frozen", 3'd4, 32'h030F0300);

        // R5 inclusive 4 KiB bounds of r0
        cur_tag = "R5";
        cyc("R5 lower bound hits", 25'h0010000, 2'b01, 1'b1, 1'b0);
        cyc("R5 upper bound hits", 25'h001FFFF, 2'b01, 1'b1, 1'b0);
        cyc("R5 below lower misses", 25'h000FFFF, 2'b01, 1'b0, 1'b0);
        cyc("R5 above upper misses", 25'h0020000, 2'b01, 1'b0, 1'b0);
        cyc("R5 single granule top", 25'h0100FFF, 2'b00, 1'b1, 1'b0);

        // R6 enable chosen by cycle kind
        cur_tag = "R6";
        cyc("R6 read in wp-only range", 25'h0015000, 2'b00, 1'b0, 1'b0);
        cyc("R6 erase in wp-only range", 25'h0015000, 2'b10, 1'b1, 1'b0);
        cyc("R6 kind 11 in wp-only range", 25'h0015000, 2'b11, 1'b1, 1'b0);
        cyc("R6 read in rp-only range", 25'h0100000, 2'b00, 1'b1, 1'b0);
        cyc("R6 write in rp-only range", 25'h0100800, 2'b01, 1'b0, 1'b0);
        cyc("R6 disabled range write", 25'h0300000, 2'b01, 1'b0, 1'b0);
        cyc("R6 disabled range read", 25'h0300000, 2'b00, 1'b0, 1'b0);

        // R7 OR over ranges, inverted window
        cur_tag = "R7";
        cyc("R7 r2 read at top", 25'h1F00000, 2'b00, 1'b1, 1'b0);
        cyc("R7 r2 write at end", 25'h1FFFFFF, 2'b01, 1'b1, 1'b0);
        cyc("R7 inverted window lo", 25'h0200000, 2'b01, 1'b0, 1'b0);
        cyc("R7 inverted window hi", 25'h01FF000, 2'b01, 1'b0, 1'b0);
        cyc("R7 gap read", 25'h0101000, 2'b00, 1'b0, 1'b0);

        // R9 sticky error and clearing
        cur_tag = "R9";
        @(posedge clk); #5;
        chk1("R9 flag set after blocks", err_flag, 1'b1);
        @(negedge clk); err_clr = 1;
        @(negedge clk); err_clr = 0;
        @(posedge clk); #5;
        chk1("R9 cleared by write-one", err_flag, 1'b0);
        cyc("R9 block with clear", 25'h0010000, 2'b01, 1'b1, 1'b1);
        chk1("R9 block wins over clear", err_flag, 1'b1);
        cyc("R9 allowed with clear", 25'h0000000, 2'b01, 1'b0, 1'b1);
        chk1("R9 clear on allowed cycle", err_flag, 1'b0);

        // R8 idle output
        cur_tag = "R8";
        repeat (2) @(posedge clk); #5;
        chk1("R8 idle dec_valid", dec_valid, 1'b0);

        // random traffic under lockdown
        cur_tag = "R7";
        random_traffic(3000, 1'b0);

        // R1 second reset clears lockdown
        do_reset();
        cur_tag = "R1";
        @(posedge clk); #5;
        chk1("R1 locked cleared", locked, 1'b0);
        chk1("R1 err cleared", err_flag, 1'b0);
        rd_chk("R1 r0 cleared", 3'd0, 32'h0);

        // random programming, lockdown mid-stream
        cur_tag = "R3";
        random_traffic(3000, 1'b1);

        repeat (2) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule